// File: doc/BRIEF.md
# Remote DMA Data-Port Engine

This block is the host side of a small packet-buffer controller. Software programs a start address and a byte count through byte-wide registers, then issues a remote read or remote write command. After that it moves the data by repeated accesses to one data port. The engine steps its internal address, counts the remaining bytes down, and raises a completion flag in a status register when the count runs out. The completion flag is cleared by writing a one to it.

A configuration bit chooses between two operating widths. In narrow mode every data-port access moves one byte, and the buffer RAM is a window of N bytes at address N. In wide mode every access moves a 16-bit word, and the window is 2N bytes at address 2N, with N = 2^`WIN_LOG2`. A read-only identity image occupies the first 32 addresses. It holds a 48-bit station address and a width signature, and its layout follows the width mode. The buffer RAM is two byte-wide banks split by address parity. This lets each bank map onto an inferred block RAM while still serving word accesses at unaligned addresses.

Top module: `rdma_port_engine`

## Requirements
- R1: After reset the command register (offset 0) reads 0x21, the status register (offset 5) reads 0x80, the configuration register (offset 6) reads 0x00, and the data-port read lane is 0x0000.
- R2: Writes to offsets 1/2 load the start address (low/high byte) and writes to offsets 3/4 load the byte count (low/high). Reads of offsets 1/2 return the current address and reads of offsets 3/4 return the remaining count, and both follow every accepted data-port access.
- R3: With configuration bit 0 clear (narrow), each accepted access moves one byte on data bits [7:0], adds 1 to the address and subtracts 1 from the count. A read returns 0x00 on bits [15:8].
- R4: With configuration bit 0 set (wide), each accepted access moves two bytes, the lower address on bits [7:0]. The address rises by 2 and the count falls by 2, and this also holds at an odd address.
- R5: When the count reaches zero, status bit 6 is set and the transfer ends. Command bits [5:3] read back 3'b100 whenever no transfer runs, and 3'b001 (read) or 3'b010 (write) while one does. A command issued with a zero count sets bit 6 at once.
- R6: Writing 1 to status bit 7 or bit 6 clears that bit. Writing 0 leaves it unchanged.
- R7: In narrow mode only addresses N..2N-1 retain written data; in wide mode only 2N..4N-1 do. Reads of other addresses above 31 return 0x00 per byte.
- R8: Addresses 0..31 read the identity image and ignore writes. In wide mode, byte k of the station address (most significant first) appears at offsets 2k and 2k+1. In narrow mode it appears at offset k. Offsets 28..31 hold 0x57 when `strap_wide` is 1 and 0x42 when it is 0. All other image bytes are 0x00.
- R9: A data-port access while no transfer runs, including after the count expired, or in the direction opposite to the running command, is ignored. The address and count do not move, no memory changes, and a read returns 0x0000.
- R10: A command write while a transfer runs stops that transfer without setting status bit 6. A command field of 3'b001 or 3'b010 restarts from the start and count registers; any other value leaves the engine idle.
- R11: In wide mode, when one byte remains, an access moves only the low byte. A write does not store bits [15:8], a read returns 0x00 there, and the address advances by 1.
- R12: Command bits [7:6] select a register page. On a page other than 0, offsets 1..7 read 0x00 and ignore writes, while offset 0 stays accessible.
- R13: Register read data appears on `reg_rdata` the cycle after `reg_rd`. Data-port read data appears on `dp_rdata` only in the cycle after an accepted `dp_rd`, and reads 0x0000 otherwise.

Here N = 2^`WIN_LOG2`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, one cycle after reg_rd |
| dp_wr | input | 1 | Data-port write strobe |
| dp_rd | input | 1 | Data-port read strobe |
| dp_wdata | input | 16 | Data-port write data |
| dp_rdata | output | 16 | Data-port read data, one cycle after an accepted read |
| strap_wide | input | 1 | Board strap selecting the image signature byte |

## Verification
The hardest situations to reach are the ones where a transfer is disturbed partway through. These are:
- a command rewritten after some bytes have moved;
- a data-port access in the wrong direction;
- a word-mode transfer with an odd count, which ends on a half word.

The stimulus reaches them by launching a transfer, performing a few accesses, and then issuing the disturbing action. Between the steps, the bench reads back the live address and count registers and the status register through the host interface. Each window is swept completely at a reduced window size, so edge addresses on both sides of the RAM and of the identity image are checked against a byte-level model.

// File: rtl/rdma_pkg.sv
package rdma_pkg;

  localparam logic [3:0] OFF_CMD    = 4'd0;
  localparam logic [3:0] OFF_ADR_LO = 4'd1;
  localparam logic [3:0] OFF_ADR_HI = 4'd2;
  localparam logic [3:0] OFF_CNT_LO = 4'd3;
  localparam logic [3:0] OFF_CNT_HI = 4'd4;
  localparam logic [3:0] OFF_STAT   = 4'd5;
  localparam logic [3:0] OFF_CFG    = 4'd6;

  localparam logic [2:0] RC_READ  = 3'b001;
  localparam logic [2:0] RC_WRITE = 3'b010;
  localparam logic [2:0] RC_IDLE  = 3'b100;

  localparam int ST_RST  = 7;
  localparam int ST_DONE = 6;

  localparam int         IMG_LEN    = 32;
  localparam logic [7:0] SIG_NARROW = 8'h42;
  localparam logic [7:0] SIG_WIDE   = 8'h57;

  typedef enum logic [1:0] {SRC_CONST, SRC_BANK0, SRC_BANK1} lane_src_e;

  // Identity image byte at offset 'off' for the given width mode and strap.
  function automatic logic [7:0] image_byte(input logic [4:0] off, input logic wide,
                                            input logic strap, input logic [47:0] st);
    int k;
    logic [7:0] v;
    v = 8'h00;
    k = 0;
    if (off >= 5'd28) begin
      v = strap ? SIG_WIDE : SIG_NARROW;
    end else if (wide && off < 5'd12) begin
      k = int'(off >> 1);
      v = st[47-8*k -: 8];
    end else if (!wide && off < 5'd6) begin
      k = int'(off);
      v = st[47-8*k -: 8];
    end
    return v;
  endfunction

endpackage

// File: rtl/rdma_bank.sv
module rdma_bank #(
  parameter int ROW_W = 9
) (
  input  logic             clk,
  input  logic             we,
  input  logic             re,
  input  logic [ROW_W-1:0] row,
  input  logic [7:0]       wd,
  output logic [7:0]       q
);
  localparam int ROWS = 1 << ROW_W;

  logic [7:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (we) mem[row] <= wd;
    if (re) q <= mem[row];
  end
endmodule

// File: rtl/rdma_store.sv
module rdma_store
  import rdma_pkg::*;
#(
  parameter int          WIN_LOG2 = 9,
  parameter logic [47:0] STATION  = 48'h00_12_34_56_78_9A
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        go,
  input  logic        wr,
  input  logic        two,
  input  logic        wide,
  input  logic        strap,
  input  logic [15:0] addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata
);
  localparam int ROW_W = WIN_LOG2;
  localparam int LANES = 2;

  logic [15:0]      lane_addr [LANES];
  logic             lane_on   [LANES];
  logic             lane_win  [LANES];
  logic             lane_img  [LANES];
  logic [ROW_W-1:0] lane_row  [LANES];
  logic [7:0]       lane_wd   [LANES];
  logic [7:0]       bank_q    [LANES];
  lane_src_e        src_q     [LANES];
  logic [7:0]       cst_q     [LANES];

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      lane_addr[l] = addr + 16'(l);
      lane_on[l]   = (l == 0) || two;
      lane_win[l]  = wide ? ((lane_addr[l] >> (WIN_LOG2 + 1)) == 16'd1)
                          : ((lane_addr[l] >> WIN_LOG2) == 16'd1);
      lane_img[l]  = lane_addr[l] < 16'(IMG_LEN);
      lane_row[l]  = wide ? lane_addr[l][WIN_LOG2:1]
                          : {1'b0, lane_addr[l][WIN_LOG2-1:1]};
      lane_wd[l]   = wdata[8*l +: 8];
    end
  end

  // Bank k holds the bytes whose address parity equals k.
  for (genvar k = 0; k < LANES; k++) begin : g_bank
    logic sel;
    logic b_we;
    logic b_re;
    assign sel  = addr[0] ^ 1'(k);
    assign b_we = go &  wr & lane_on[sel] & lane_win[sel];
    assign b_re = go & ~wr & lane_on[sel] & lane_win[sel];
    rdma_bank #(.ROW_W(ROW_W)) u_bank (
      .clk (clk),
      .we  (b_we),
      .re  (b_re),
      .row (lane_row[sel]),
      .wd  (lane_wd[sel]),
      .q   (bank_q[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int l = 0; l < LANES; l++) begin
        src_q[l] <= SRC_CONST;
        cst_q[l] <= 8'h00;
      end
    end else begin
      for (int l = 0; l < LANES; l++) begin
        if (go && !wr && lane_on[l]) begin
          if (lane_win[l]) begin
            src_q[l] <= lane_addr[l][0] ? SRC_BANK1 : SRC_BANK0;
            cst_q[l] <= 8'h00;
          end else begin
            src_q[l] <= SRC_CONST;
            cst_q[l] <= lane_img[l] ? image_byte(lane_addr[l][4:0], wide, strap, STATION)
                                    : 8'h00;
          end
        end else begin
          src_q[l] <= SRC_CONST;
          cst_q[l] <= 8'h00;
        end
      end
    end
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      case (src_q[l])
        SRC_BANK0: rdata[8*l +: 8] = bank_q[0];
        SRC_BANK1: rdata[8*l +: 8] = bank_q[1];
        default:   rdata[8*l +: 8] = cst_q[l];
      endcase
    end
  end
endmodule

// File: rtl/rdma_ctrl.sv
module rdma_ctrl
  import rdma_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [3:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic        dp_wr,
  input  logic        dp_rd,
  output logic        xfer_go,
  output logic        xfer_wr,
  output logic        xfer_two,
  output logic        xfer_last,
  output logic [15:0] cur_addr,
  output logic        wide,
  output logic        act,
  output logic        done_flag,
  output logic [1:0]  page
);
  logic [15:0] remain;
  logic [7:0]  start_lo, start_hi, cnt_lo, cnt_hi;
  logic        txp, sta, stp, rst_flag;
  logic        cmd_wr, pg0_wr, launch, set_done;
  logic [2:0]  rc_field, rc_view;
  logic [1:0]  step;
  logic [15:0] start_val, count_val;

  assign cmd_wr    = reg_wr && (reg_addr == OFF_CMD);
  assign pg0_wr    = reg_wr && (page == 2'd0);
  assign rc_field  = reg_wdata[5:3];
  assign launch    = cmd_wr && (rc_field == RC_READ || rc_field == RC_WRITE);
  assign start_val = {start_hi, start_lo};
  assign count_val = {cnt_hi, cnt_lo};

  assign xfer_wr   = act && !cmd_wr && xfer_dir_wr;
  assign xfer_go   = act && !cmd_wr && (xfer_dir_wr ? dp_wr : dp_rd);
  assign xfer_two  = wide && (remain != 16'd1);
  assign step      = xfer_two ? 2'd2 : 2'd1;
  assign xfer_last = remain == {14'd0, step};
  assign set_done  = (xfer_go && xfer_last) || (launch && count_val == 16'd0);
  assign rc_view   = act ? (xfer_dir_wr ? RC_WRITE : RC_READ) : RC_IDLE;

  logic xfer_dir_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      act         <= 1'b0;
      xfer_dir_wr <= 1'b0;
      cur_addr    <= 16'd0;
      remain      <= 16'd0;
      page        <= 2'd0;
      txp         <= 1'b0;
      sta         <= 1'b0;
      stp         <= 1'b1;
    end else if (cmd_wr) begin
      page <= reg_wdata[7:6];
      txp  <= reg_wdata[2];
      sta  <= reg_wdata[1];
      stp  <= reg_wdata[0];
      if (launch) begin
        cur_addr    <= start_val;
        remain      <= count_val;
        xfer_dir_wr <= (rc_field == RC_WRITE);
        act         <= (count_val != 16'd0);
      end else begin
        act <= 1'b0;
      end
    end else if (xfer_go) begin
      cur_addr <= cur_addr + 16'(step);
      remain   <= remain - 16'(step);
      if (xfer_last) act <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_lo  <= 8'h00;
      start_hi  <= 8'h00;
      cnt_lo    <= 8'h00;
      cnt_hi    <= 8'h00;
      wide      <= 1'b0;
      rst_flag  <= 1'b1;
      done_flag <= 1'b0;
    end else begin
      if (pg0_wr) begin
        case (reg_addr)
          OFF_ADR_LO: start_lo <= reg_wdata;
          OFF_ADR_HI: start_hi <= reg_wdata;
          OFF_CNT_LO: cnt_lo   <= reg_wdata;
          OFF_CNT_HI: cnt_hi   <= reg_wdata;
          OFF_CFG:    wide     <= reg_wdata[0];
          default: ;
        endcase
      end
      if (pg0_wr && reg_addr == OFF_STAT && reg_wdata[ST_RST]) rst_flag <= 1'b0;
      if (set_done)
        done_flag <= 1'b1;
      else if (pg0_wr && reg_addr == OFF_STAT && reg_wdata[ST_DONE])
        done_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= 8'h00;
    end else if (reg_rd) begin
      if (reg_addr == OFF_CMD) begin
        reg_rdata <= {page, rc_view, txp, sta, stp};
      end else if (page != 2'd0) begin
        reg_rdata <= 8'h00;
      end else begin
        case (reg_addr)
          OFF_ADR_LO: reg_rdata <= cur_addr[7:0];
          OFF_ADR_HI: reg_rdata <= cur_addr[15:8];
          OFF_CNT_LO: reg_rdata <= remain[7:0];
          OFF_CNT_HI: reg_rdata <= remain[15:8];
          OFF_STAT:   reg_rdata <= {rst_flag, done_flag, 6'd0};
          OFF_CFG:    reg_rdata <= {7'd0, wide};
          default:    reg_rdata <= 8'h00;
        endcase
      end
    end
  end
endmodule

// File: rtl/rdma_port_engine.sv
module rdma_port_engine #(
  parameter int          WIN_LOG2 = 9,
  parameter logic [47:0] STATION  = 48'h00_12_34_56_78_9A
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [3:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic        dp_wr,
  input  logic        dp_rd,
  input  logic [15:0] dp_wdata,
  output logic [15:0] dp_rdata,
  input  logic        strap_wide
);
  logic        x_go, x_wr, x_two, x_last;
  logic [15:0] x_addr;
  logic        ctl_wide, ctl_act, ctl_done;
  logic [1:0]  ctl_page;

  rdma_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .dp_wr     (dp_wr),
    .dp_rd     (dp_rd),
    .xfer_go   (x_go),
    .xfer_wr   (x_wr),
    .xfer_two  (x_two),
    .xfer_last (x_last),
    .cur_addr  (x_addr),
    .wide      (ctl_wide),
    .act       (ctl_act),
    .done_flag (ctl_done),
    .page      (ctl_page)
  );

  rdma_store #(.WIN_LOG2(WIN_LOG2), .STATION(STATION)) u_store (
    .clk   (clk),
    .rst   (rst),
    .go    (x_go),
    .wr    (x_wr),
    .two   (x_two),
    .wide  (ctl_wide),
    .strap (strap_wide),
    .addr  (x_addr),
    .wdata (dp_wdata),
    .rdata (dp_rdata)
  );
endmodule

// File: rtl/rdma_port_engine_chk.sv
module rdma_port_engine_chk (
  input logic        clk,
  input logic        rst,
  input logic        reg_wr,
  input logic [3:0]  reg_addr,
  input logic [7:0]  reg_wdata,
  input logic        act,
  input logic        done_flag,
  input logic [1:0]  page,
  input logic        go,
  input logic        two,
  input logic        last,
  input logic [15:0] cur,
  input logic        wide
);
  // R9
  idle_ignore_chk: assert property (@(posedge clk) disable iff (rst) !act |-> !go);

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    go |=> cur == $past(cur) + ($past(two) ? 16'd2 : 16'd1));

  // R5
  last_done_chk: assert property (@(posedge clk) disable iff (rst)
    (go && last) |=> (!act && done_flag));

  // R6
  w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 4'd5 && page == 2'd0 && reg_wdata[6] && !go) |=> !done_flag);

  // R10
  abort_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (act && reg_wr && reg_addr == 4'd0 && reg_wdata[5] && !done_flag) |=> (!act && !done_flag));

  // R4
  word_only_wide_chk: assert property (@(posedge clk) disable iff (rst)
    (go && two) |-> wide);

  // R11
  odd_tail_chk: assert property (@(posedge clk) disable iff (rst)
    (go && wide && !two) |-> last);
endmodule

bind rdma_port_engine rdma_port_engine_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .act       (ctl_act),
  .done_flag (ctl_done),
  .page      (ctl_page),
  .go        (x_go),
  .two       (x_two),
  .last      (x_last),
  .cur       (x_addr),
  .wide      (ctl_wide)
);

// File: tb/rdma_port_engine_tb_top.sv
module rdma_port_engine_tb_top;
  localparam int          W  = 6;
  localparam int          N  = 1 << W;
  localparam logic [47:0] ST = 48'hA1_B2_C3_D4_E5_F6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = 4'd0;
  logic [7:0]  reg_wdata = 8'd0;
  logic [7:0]  reg_rdata;
  logic        dp_wr = 1'b0, dp_rd = 1'b0;
  logic [15:0] dp_wdata = 16'd0;
  logic [15:0] dp_rdata;
  logic        strap_wide = 1'b0;

  int checks = 0;
  int errors = 0;
  bit ended  = 0;
  logic [7:0] ph [2*N];

  always #2 clk = ~clk;

  rdma_port_engine #(.WIN_LOG2(W), .STATION(ST)) dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dp_wr(dp_wr), .dp_rd(dp_rd),
    .dp_wdata(dp_wdata), .dp_rdata(dp_rdata), .strap_wide(strap_wide)
  );

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Identity image as stated in R8.
  function automatic logic [7:0] img(input int off, input bit wide, input bit strap);
    if (off >= 28) return strap ? 8'h57 : 8'h42;
    if (wide && off < 12) return ST[47-8*(off/2) -: 8];
    if (!wide && off < 6) return ST[47-8*off -: 8];
    return 8'h00;
  endfunction

  task automatic rw(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rr(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic chk_reg(input string tag, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rr(a, d);
    chk(tag, {8'h00, d}, {8'h00, exp});
  endtask

  task automatic chk_pos(input string tag, input int ad, input int cnt);
    chk_reg(tag, 4'd1, 8'(ad));
    chk_reg(tag, 4'd2, 8'(ad >> 8));
    chk_reg(tag, 4'd3, 8'(cnt));
    chk_reg(tag, 4'd4, 8'(cnt >> 8));
  endtask

  task automatic dpw(input logic [15:0] d);
    @(negedge clk); dp_wr = 1'b1; dp_wdata = d;
    @(negedge clk); dp_wr = 1'b0;
  endtask

  task automatic dpr(output logic [15:0] d);
    @(negedge clk); dp_rd = 1'b1;
    @(negedge clk); dp_rd = 1'b0; d = dp_rdata;
  endtask

  task automatic launch(input int start, input int count, input bit write);
    rw(4'd5, 8'hFF);
    rw(4'd1, 8'(start)); rw(4'd2, 8'(start >> 8));
    rw(4'd3, 8'(count)); rw(4'd4, 8'(count >> 8));
    rw(4'd0, write ? 8'h12 : 8'h0A);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    logic [15:0] d;
    logic [15:0] w;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 dp_rdata", dp_rdata, 16'h0000);
    chk_reg("R1 cmd", 4'd0, 8'h21);
    chk_reg("R1 status", 4'd5, 8'h80);
    chk_reg("R1 config", 4'd6, 8'h00);

    // R6 write-one-to-clear
    rw(4'd5, 8'h00);
    chk_reg("R6 zero write keeps", 4'd5, 8'h80);
    rw(4'd5, 8'h80);
    chk_reg("R6 one clears", 4'd5, 8'h00);

    // R3 narrow sweep of whole window
    launch(N, N, 1);
    chk_reg("R5 cmd during write", 4'd0, 8'h12);
    for (int i = 0; i < N; i++) begin
      ph[i] = 8'(i * 37 + 11);
      dpw({8'hEE, ph[i]});
      if (i == 20) chk_pos("R2 narrow position", N + 21, N - 21);
    end
    chk_reg("R5 done set", 4'd5, 8'h40);
    chk_reg("R5 cmd idle", 4'd0, 8'h22);
    rw(4'd5, 8'h80);
    chk_reg("R6 other bit kept", 4'd5, 8'h40);
    rw(4'd5, 8'h40);
    chk_reg("R6 done cleared", 4'd5, 8'h00);
    launch(N, N, 0);
    for (int i = 0; i < N; i++) begin
      dpr(d);
      chk("R3 narrow read", d, {8'h00, ph[i]});
    end
    // R13 data valid for one cycle only
    @(negedge clk);
    chk("R13 rdata drops", dp_rdata, 16'h0000);

    // R7 narrow write straddling the upper window edge
    launch(2*N - 8, 16, 1);
    for (int i = 0; i < 16; i++) begin
      dpw({8'h00, 8'(8'h50 + i)});
      if (i < 8) ph[N - 8 + i] = 8'(8'h50 + i);
    end
    launch(2*N - 8, 16, 0);
    for (int i = 0; i < 16; i++) begin
      dpr(d);
      chk("R7 narrow edge", d, (i < 8) ? {8'h00, ph[N - 8 + i]} : 16'h0000);
    end
    launch(40, 4, 0);
    for (int i = 0; i < 4; i++) begin
      dpr(d);
      chk("R7 gap below window", d, 16'h0000);
    end

    // R8 narrow image, strap low
    strap_wide = 1'b0;
    launch(0, 32, 0);
    for (int i = 0; i < 32; i++) begin
      dpr(d);
      chk("R8 narrow image", d, {8'h00, img(i, 0, 0)});
    end

    // R4 wide sweep
    rw(4'd6, 8'h01);
    launch(2*N, 2*N, 1);
    for (int i = 0; i < N; i++) begin
      w = 16'(i * 16'h1357 + 16'h2468);
      ph[2*i] = w[7:0];
      ph[2*i+1] = w[15:8];
      dpw(w);
      if (i == 10) chk_pos("R2 wide position", 2*N + 22, 2*N - 22);
    end
    chk_reg("R5 wide done", 4'd5, 8'h40);
    launch(2*N, 2*N, 0);
    for (int i = 0; i < N; i++) begin
      dpr(d);
      chk("R4 wide read", d, {ph[2*i+1], ph[2*i]});
    end
    launch(2*N + 1, 4, 0);
    dpr(d); chk("R4 odd address", d, {ph[2], ph[1]});
    dpr(d); chk("R4 odd address", d, {ph[4], ph[3]});
    chk_pos("R2 after odd address", 2*N + 5, 0);
    launch(N, 2, 0);
    dpr(d); chk("R7 narrow area in wide mode", d, 16'h0000);

    // R11 odd count in word mode
    launch(200, 3, 1);
    dpw(16'hAABB);
    dpw(16'hCCDD);
    ph[72] = 8'hBB; ph[73] = 8'hAA; ph[74] = 8'hDD;
    chk_pos("R11 tail position", 203, 0);
    chk_reg("R11 tail done", 4'd5, 8'h40);
    launch(200, 4, 0);
    dpr(d); chk("R11 readback", d, {8'hAA, 8'hBB});
    dpr(d); chk("R11 high byte kept", d, {ph[75], 8'hDD});
    launch(200, 3, 0);
    dpr(d);
    dpr(d); chk("R11 tail read", d, {8'h00, 8'hDD});

    // R8 wide image, strap high, and writes ignored
    strap_wide = 1'b1;
    launch(0, 2, 1);
    dpw(16'hFFFF);
    launch(0, 32, 0);
    for (int i = 0; i < 16; i++) begin
      dpr(d);
      chk("R8 wide image", d, {img(2*i+1, 1, 1), img(2*i, 1, 1)});
    end

    // R9 ignored accesses
    dpr(d); chk("R9 read after expiry", d, 16'h0000);
    dpw(16'h7777);
    chk_pos("R9 idle write no move", 32, 0);
    launch(140, 4, 1);
    dpr(d); chk("R9 wrong direction read", d, 16'h0000);
    chk_pos("R9 wrong direction no move", 140, 4);
    dpw(16'h2222); dpw(16'h2222);
    ph[12] = 8'h22; ph[13] = 8'h22; ph[14] = 8'h22; ph[15] = 8'h22;

    // R10 abort and restart
    launch(160, 10, 1);
    dpw(16'h1111);
    ph[32] = 8'h11; ph[33] = 8'h11;
    rw(4'd0, 8'h22);
    chk_reg("R10 abort cmd", 4'd0, 8'h22);
    chk_reg("R10 abort no done", 4'd5, 8'h00);
    dpw(16'h9999);
    chk_pos("R10 aborted frozen", 162, 8);
    launch(2*N, 8, 0);
    dpr(d); chk("R10 first read", d, {ph[1], ph[0]});
    rw(4'd1, 8'(2*N + 12)); rw(4'd2, 8'h00);
    rw(4'd3, 8'd4); rw(4'd4, 8'd0);
    rw(4'd0, 8'h0A);
    chk_pos("R10 restart position", 2*N + 12, 4);
    chk_reg("R10 restart no done", 4'd5, 8'h00);
    dpr(d); chk("R10 restart data", d, {ph[13], ph[12]});
    dpr(d); chk("R10 restart data", d, {ph[15], ph[14]});
    chk_reg("R10 restart done", 4'd5, 8'h40);
    launch(160, 2, 0);
    dpr(d); chk("R10 data before abort", d, {ph[33], ph[32]});

    // R5 zero count
    launch(100, 0, 1);
    chk_reg("R5 zero count done", 4'd5, 8'h40);
    chk_reg("R5 zero count idle", 4'd0, 8'h22);

    // R12 page select
    rw(4'd0, 8'h62);
    chk_reg("R12 cmd page", 4'd0, 8'h62);
    rw(4'd6, 8'h00);
    chk_reg("R12 page read zero", 4'd6, 8'h00);
    rw(4'd0, 8'h22);
    chk_reg("R12 write ignored", 4'd6, 8'h01);

    finish_up();
  end
endmodule